// File: doc/BRIEF.md
# Two-Phase Mailbox Bootstrap Register

This block implements the device side of a single 32-bit doorbell that lets host software post a command before any command rings exist. The command's mailbox lives at a 60-bit physical address, which the host delivers in two writes to the same register. The first write carries the upper address half. The second write carries the lower half. Between the writes, and after the second one, the host polls a ready bit.

On the upper-half write the block latches the address bits and acknowledges them by raising ready. On the lower-half write it clears ready, joins both halves and pulses a start request toward a backend. The backend fetches and executes the mailbox command, which is outside this block. When the backend pulses done, ready rises again to report that the command has completed. Writes that break the two-phase protocol are dropped and raise a sticky error flag.

Top module: `mbx_bootstrap_reg`

## Requirements
- R1: After a synchronous active-high reset, ready, the read word, the start pulse and the protocol-error flag are all 0, and the block is idle.
- R2: A write word is decoded as a phase flag at bit 1 and a 30-bit address field at bits 31:2. The value written to bit 0 has no effect on ready.
- R3: A write with bit 1 set, made while no command is running, latches the address field as the upper half. Ready reads 1 from the cycle after that write.
- R4: A write with bit 1 clear, made while an upper half is held, produces a start pulse exactly one cycle wide in the cycle after the write. The start address is {upper field, lower field}, 60 bits wide.
- R5: Ready is 0 from the cycle after the lower-half write until the backend's done pulse. Ready reads 1 in the cycle after done.
- R6: A lower-half write while no upper half is held (after reset, or after a completed command) is ignored. It causes no start pulse, leaves ready unchanged and sets the error flag.
- R7: Any write while a command is running is ignored and sets the error flag. Ready stays 0, no start pulse occurs, and the command still completes on done.
- R8: The error flag stays set until reset, even while later commands complete normally.
- R9: A second upper-half write before the lower half replaces the held upper half.
- R10: A done pulse while no command is running has no effect on ready or on the held upper half.
- R11: After completion, a new upper-half write begins a new command, and the next start carries the new address.
- R12: The read word has ready at bit 0, the phase flag of the last accepted write at bit 1, and zeros in bits 31:2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write word: phase flag at bit 1, address field at bits 31:2 |
| rd_data | output | 32 | Read word: ready at bit 0, last accepted phase flag at bit 1 |
| cmd_start | output | 1 | One-cycle request to the backend |
| cmd_addr | output | 60 | Joined mailbox address, valid with cmd_start |
| cmd_done | input | 1 | One-cycle completion pulse from the backend |
| proto_err | output | 1 | Sticky flag for writes that break the protocol |

## Verification
The assertions check on every cycle that start is a single-cycle pulse and is never seen together with ready. They also check that the error flag never clears outside reset, that a write during a running command produces neither start nor ready, and that done during a running command raises ready. Only the bench scenarios can show the address a start carries, including replacement of the upper half and a second command. They also show that each ignored write, or a stray done, leaves the read word unchanged.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLAG_BIT = 1;
  localparam int unsigned RDY_BIT  = 0;
  localparam int unsigned FIELD_LO = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UPPER = 2'd1,
    ST_BUSY  = 2'd2,
    ST_DONE  = 2'd3
  } mbx_state_e;
endpackage

// File: rtl/mbx_word_split.sv
module mbx_word_split
  import mbx_pkg::*;
#(
  parameter int unsigned FIELD_W = 30
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic               phase_hi_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int unsigned FIELD_HI = FIELD_LO + FIELD_W - 1;

  always_comb begin
    phase_hi_o = word_i[FLAG_BIT];
    field_o    = word_i[FIELD_HI:FIELD_LO];
  end
endmodule

// File: rtl/mbx_addr_hold.sv
module mbx_addr_hold #(
  parameter int unsigned FIELD_W = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_we_i,
  input  logic                 lo_we_i,
  input  logic [FIELD_W-1:0]   field_i,
  output logic [2*FIELD_W-1:0] full_addr_o
);
  localparam int unsigned FULL_W = 2 * FIELD_W;

  logic [FIELD_W-1:0] upper_q;
  logic [FULL_W-1:0]  full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      full_q  <= '0;
    end else begin
      if (up_we_i) upper_q <= field_i;
      if (lo_we_i) full_q  <= {upper_q, field_i};
    end
  end

  assign full_addr_o = full_q;

  // R4: the joined address only moves on a lower-half write
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !lo_we_i |=> $stable(full_q));
endmodule

// File: rtl/mbx_phase_fsm.sv
module mbx_phase_fsm
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en_i,
  input  logic phase_hi_i,
  input  logic done_i,
  output logic up_we_o,
  output logic lo_we_o,
  output logic start_o,
  output logic ready_o,
  output logic last_hi_o,
  output logic err_o
);
  mbx_state_e state_q, state_d;
  logic start_q, ready_q, last_hi_q, err_q;
  logic bad_wr;

  always_comb begin
    up_we_o = wr_en_i &&  phase_hi_i && (state_q != ST_BUSY);
    lo_we_o = wr_en_i && !phase_hi_i && (state_q == ST_UPPER);
    bad_wr  = wr_en_i && !up_we_o && !lo_we_o;
    state_d = state_q;
    if (up_we_o)
      state_d = ST_UPPER;
    else if (lo_we_o)
      state_d = ST_BUSY;
    else if ((state_q == ST_BUSY) && done_i)
      state_d = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      start_q   <= 1'b0;
      ready_q   <= 1'b0;
      last_hi_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= lo_we_o;
      if (up_we_o)
        ready_q <= 1'b1;
      else if (lo_we_o)
        ready_q <= 1'b0;
      else if ((state_q == ST_BUSY) && done_i)
        ready_q <= 1'b1;
      if (up_we_o || lo_we_o) last_hi_q <= phase_hi_i;
      if (bad_wr) err_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign ready_o   = ready_q;
  assign last_hi_o = last_hi_q;
  assign err_o     = err_q;

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  assert_ready_low_on_start_R5: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !ready_q);
  assert_done_sets_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && done_i) |=> ready_q);
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && state_q == ST_BUSY && !done_i) |=> (!start_q && !ready_q && err_q));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/mbx_bootstrap_reg.sv
module mbx_bootstrap_reg
  import mbx_pkg::*;
#(
  parameter int unsigned FIELD_W = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  output logic                 cmd_start,
  output logic [2*FIELD_W-1:0] cmd_addr,
  input  logic                 cmd_done,
  output logic                 proto_err
);
  logic               phase_hi;
  logic [FIELD_W-1:0] field;
  logic               up_we, lo_we, ready, last_hi;

  mbx_word_split #(.FIELD_W(FIELD_W)) split_i (
    .word_i     (wr_data),
    .phase_hi_o (phase_hi),
    .field_o    (field)
  );

  mbx_phase_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .phase_hi_i (phase_hi),
    .done_i     (cmd_done),
    .up_we_o    (up_we),
    .lo_we_o    (lo_we),
    .start_o    (cmd_start),
    .ready_o    (ready),
    .last_hi_o  (last_hi),
    .err_o      (proto_err)
  );

  mbx_addr_hold #(.FIELD_W(FIELD_W)) hold_i (
    .clk         (clk),
    .rst         (rst),
    .up_we_i     (up_we),
    .lo_we_i     (lo_we),
    .field_i     (field),
    .full_addr_o (cmd_addr)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[RDY_BIT]  = ready;
    rd_data[FLAG_BIT] = last_hi;
  end

  // R12: upper bits of the read word are always zero
  assert_rd_upper_zero_R12: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:2] == '0);
endmodule

// File: tb/mbx_bootstrap_reg_tb_top.sv
`timescale 1ns/1ps
module mbx_bootstrap_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cmd_done = 1'b0;
  logic [31:0] rd_data;
  logic        cmd_start;
  logic [59:0] cmd_addr;
  logic        proto_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mbx_bootstrap_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_done(cmd_done), .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; cmd_done = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // one write; returns at the negedge after the capturing edge
  task automatic do_write(input logic hi, input logic [29:0] fld, input logic b0);
    @(negedge clk); wr_en = 1'b1; wr_data = {fld, hi, b0};
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd_data", 64'(rd_data), 64'h0);
    check("R1 start", 64'(cmd_start), 64'h0);
    check("R1 err", 64'(proto_err), 64'h0);
  endtask

  task automatic t_basic();
    do_reset();
    do_write(1'b1, 30'h2ABC_1234, 1'b0);
    check("R3 ready after upper", 64'(rd_data), 64'h3);
    do_write(1'b0, 30'h1357_9BDF, 1'b1);
    check("R4 start", 64'(cmd_start), 64'h1);
    check("R4 addr", 64'(cmd_addr), {4'h0, 30'h2ABC_1234, 30'h1357_9BDF});
    check("R5 ready low", 64'(rd_data), 64'h0);
    idle(1);
    check("R4 single pulse", 64'(cmd_start), 64'h0);
    idle(3);
    check("R5 still low", 64'(rd_data[0]), 64'h0);
    do_done();
    check("R5 ready after done", 64'(rd_data[0]), 64'h1);
    check("R12 read word", 64'(rd_data), 64'h1);
    check("R2 no error", 64'(proto_err), 64'h0);
  endtask

  task automatic t_bad_lower();
    do_reset();
    do_write(1'b0, 30'h0000_0ABC, 1'b1);
    check("R6 ignored rd", 64'(rd_data), 64'h0);
    check("R6 no start", 64'(cmd_start), 64'h0);
    check("R6 err set", 64'(proto_err), 64'h1);
    do_write(1'b1, 30'h0111_1111, 1'b0);
    do_write(1'b0, 30'h0222_2222, 1'b0);
    do_done();
    check("R8 err kept", 64'(proto_err), 64'h1);
    do_write(1'b0, 30'h0333_3333, 1'b0);
    check("R6 after completion no start", 64'(cmd_start), 64'h0);
    check("R6 ready unchanged", 64'(rd_data[0]), 64'h1);
  endtask

  task automatic t_busy_write();
    do_reset();
    do_write(1'b1, 30'h0AAA_AAAA, 1'b0);
    do_write(1'b0, 30'h0555_5555, 1'b0);
    do_write(1'b1, 30'h3FFF_FFFF, 1'b1);
    check("R7 ready low", 64'(rd_data), 64'h0);
    check("R7 no start", 64'(cmd_start), 64'h0);
    check("R7 err", 64'(proto_err), 64'h1);
    do_write(1'b0, 30'h0123_4567, 1'b0);
    check("R7 no start lo", 64'(cmd_start), 64'h0);
    check("R7 addr kept", 64'(cmd_addr), {4'h0, 30'h0AAA_AAAA, 30'h0555_5555});
    do_done();
    check("R7 completes", 64'(rd_data[0]), 64'h1);
  endtask

  task automatic t_replace();
    do_reset();
    do_write(1'b1, 30'h0000_0001, 1'b0);
    do_write(1'b1, 30'h3000_0007, 1'b0);
    do_write(1'b0, 30'h0F0F_0F0F, 1'b0);
    check("R9 replaced upper", 64'(cmd_addr), {4'h0, 30'h3000_0007, 30'h0F0F_0F0F});
    check("R9 no error", 64'(proto_err), 64'h0);
  endtask

  task automatic t_stray_done();
    do_reset();
    do_done();
    check("R10 ready idle", 64'(rd_data[0]), 64'h0);
    do_write(1'b1, 30'h1234_5678, 1'b0);
    do_done();
    check("R10 ready kept", 64'(rd_data), 64'h3);
    do_write(1'b0, 30'h0765_4321, 1'b0);
    check("R10 start after stray", 64'(cmd_start), 64'h1);
    check("R10 upper kept", 64'(cmd_addr), {4'h0, 30'h1234_5678, 30'h0765_4321});
  endtask

  task automatic t_second();
    do_reset();
    do_write(1'b1, 30'h0000_00AA, 1'b0);
    do_write(1'b0, 30'h0000_00BB, 1'b0);
    do_done();
    do_write(1'b1, 30'h2468_ACE0, 1'b0);
    check("R11 ready", 64'(rd_data), 64'h3);
    do_write(1'b0, 30'h1357_9BD1, 1'b0);
    check("R11 start", 64'(cmd_start), 64'h1);
    check("R11 addr", 64'(cmd_addr), {4'h0, 30'h2468_ACE0, 30'h1357_9BD1});
    check("R12 hi low", 64'(rd_data), 64'h0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_bad_lower();
    t_busy_write();
    t_replace();
    t_stray_done();
    t_second();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule